// File: doc/BRIEF.md
# Mailbox Interrupt Flag Controller

This block gives the two ports of a shared 1K x 8 memory a way to signal each other. Two locations at the top of the address space serve as mailboxes. The left port's mailbox is 0x3FE and the right port's mailbox is 0x3FF. When one port writes into the other port's mailbox, an active-low interrupt flag is raised toward the receiving port. The receiving port lowers that flag by reading its own mailbox.

The mailbox bytes stay in the shared array, which lies outside this block. The controller only watches the control and address inputs of each port. It never sees or interprets the data.

All decisions are sampled on the rising edge of the clock, and the flag outputs change one cycle after the qualifying access. A global enable switches interrupt generation off. While it is low, both flags are held deasserted.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: During reset and after reset, both `irq_left_no` and `irq_right_no` are high, meaning deasserted.
- R2: A right-port write sets the left flag. The access must have `cs_right_i`=1, `we_right_i`=1 and `busy_right_i`=0 at address 0x3FE. `irq_left_no` then goes low in the cycle after that clock edge.
- R3: A left-port write sets the right flag. The access must have `cs_left_i`=1, `we_left_i`=1 and `busy_left_i`=0 at address 0x3FF. `irq_right_no` then goes low in the cycle after that clock edge.
- R4: The left port clears its own flag with an access where `cs_left_i`=1 and `oe_left_i`=1 at 0x3FE. `irq_left_no` then returns high on the next cycle, whatever the level of `we_left_i`.
- R5: The right port clears its own flag with an access where `cs_right_i`=1 and `oe_right_i`=1 at 0x3FF. `irq_right_no` then returns high on the next cycle, whatever the level of `we_right_i`.
- R6: A write to the peer's mailbox made while the writer's busy input is 1 leaves the receiving flag unchanged.
- R7: If a set event and a clear event reach the same flag in the same cycle, the flag ends up asserted (low).
- R8: While `irq_en_i`=0, both outputs are high and set events are discarded. After the enable returns to 1, a flag stays high until a new set event arrives.
- R9: The following accesses have no effect on either flag:
  - any access at an address other than the two mailboxes;
  - a write with chip select low;
  - a port writing its own mailbox;
  - a port reading the peer's mailbox.
- R10: With no set event and no clear event, each flag keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_en_i | input | 1 | Interrupt generation enable |
| cs_left_i | input | 1 | Left port chip select, active high |
| we_left_i | input | 1 | Left port write (1) / read (0) |
| oe_left_i | input | 1 | Left port output enable, active high |
| busy_left_i | input | 1 | Left port is blocked by arbitration |
| addr_left_i | input | 10 | Left port address |
| cs_right_i | input | 1 | Right port chip select, active high |
| we_right_i | input | 1 | Right port write (1) / read (0) |
| oe_right_i | input | 1 | Right port output enable, active high |
| busy_right_i | input | 1 | Right port is blocked by arbitration |
| addr_right_i | input | 10 | Right port address |
| irq_left_no | output | 1 | Interrupt to left port, active low, always driven |
| irq_right_no | output | 1 | Interrupt to right port, active low, always driven |

## Verification
Each flag is a single state bit, so any corruption shows directly on its output pin. The error is visible at the first sample after the faulty edge, and it persists until the next legitimate set or clear event. A decode fault shows up in the following ways:
- a wrong mailbox address or a swapped port pairing raises or drops the wrong pin one cycle after the access;
- a missing busy gate shows up as a flag falling after a blocked write;
- reversed set/clear priority leaves a pin high after a simultaneous set and clear.

The bench compares both pins every cycle against a reference model. It runs directed cases for each event and for its corner cases, and random traffic biased toward the mailbox addresses.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int NUM_SIDES = 2;
  localparam int SIDE_LEFT = 0;
  localparam int SIDE_RIGHT = 1;

  function automatic int peer_side(input int side);
    return (NUM_SIDES - 1) - side;
  endfunction
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode #(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] OWN_MBOX = '1,
  parameter logic [ADDR_W-1:0] PEER_MBOX = '0
) (
  input  logic              cs_i,
  input  logic              we_i,
  input  logic              oe_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              peer_set_o,
  output logic              own_clr_o
);
  logic hit_own, hit_peer;

  assign hit_own = (addr_i == OWN_MBOX);
  assign hit_peer = (addr_i == PEER_MBOX);

  // blocked writes are gated internally
  assign peer_set_o = cs_i && we_i && !busy_i && hit_peer;
  // write level is irrelevant for the clear
  assign own_clr_o = cs_i && oe_i && hit_own;
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_no
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else if (!en_i) flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;   // set wins over clear
    else if (clr_i) flag_q <= 1'b0;
  end

  assign irq_no = ~flag_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && set_i |=> !irq_no); // R7
  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && clr_i && !set_i |=> irq_no); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !set_i && !clr_i |=> $stable(irq_no)); // R10
  AST_OFF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> irq_no); // R8
endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_en_i,
  input  logic              cs_left_i,
  input  logic              we_left_i,
  input  logic              oe_left_i,
  input  logic              busy_left_i,
  input  logic [ADDR_W-1:0] addr_left_i,
  input  logic              cs_right_i,
  input  logic              we_right_i,
  input  logic              oe_right_i,
  input  logic              busy_right_i,
  input  logic [ADDR_W-1:0] addr_right_i,
  output logic              irq_left_no,
  output logic              irq_right_no
);
  localparam logic [ADDR_W-1:0] MBOX_RIGHT = '1;
  localparam logic [ADDR_W-1:0] MBOX_LEFT = MBOX_RIGHT - 1'b1;

  logic [NUM_SIDES-1:0] cs, we, oe, busy, peer_set, own_clr, irq_n;
  logic [NUM_SIDES-1:0][ADDR_W-1:0] addr;

  assign cs = {cs_right_i, cs_left_i};
  assign we = {we_right_i, we_left_i};
  assign oe = {oe_right_i, oe_left_i};
  assign busy = {busy_right_i, busy_left_i};
  assign addr = {addr_right_i, addr_left_i};

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    localparam logic [ADDR_W-1:0] OWN = (s == SIDE_LEFT) ? MBOX_LEFT : MBOX_RIGHT;
    localparam logic [ADDR_W-1:0] PEER = (s == SIDE_LEFT) ? MBOX_RIGHT : MBOX_LEFT;

    mbox_decode #(.ADDR_W(ADDR_W), .OWN_MBOX(OWN), .PEER_MBOX(PEER)) u_dec (
      .cs_i(cs[s]), .we_i(we[s]), .oe_i(oe[s]), .busy_i(busy[s]),
      .addr_i(addr[s]), .peer_set_o(peer_set[s]), .own_clr_o(own_clr[s])
    );

    // this side's flag is set by the opposite side's write
    mbox_flag u_flag (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(irq_en_i),
      .set_i(peer_set[peer_side(s)]), .clr_i(own_clr[s]), .irq_no(irq_n[s])
    );
  end

  assign irq_left_no = irq_n[SIDE_LEFT];
  assign irq_right_no = irq_n[SIDE_RIGHT];

  AST_LEFT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_en_i && cs_right_i && we_right_i && !busy_right_i && addr_right_i == MBOX_LEFT
    |=> !irq_left_no); // R2
  AST_RIGHT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_en_i && cs_left_i && we_left_i && !busy_left_i && addr_left_i == MBOX_RIGHT
    |=> !irq_right_no); // R3
  AST_BUSY_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_en_i && busy_right_i && !(cs_left_i && oe_left_i && addr_left_i == MBOX_LEFT)
    |=> $stable(irq_left_no)); // R6
  AST_RIGHT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_right_i && oe_right_i && addr_right_i == MBOX_RIGHT &&
    !(cs_left_i && we_left_i && !busy_left_i && addr_left_i == MBOX_RIGHT)
    |=> irq_right_no); // R5
  always_comb if (!rst_ni) AST_RESET_IDLE: assert (irq_left_no && irq_right_no); // R1
endmodule

// File: tb/sim_mbox_irq_ctrl.sv
module sim_mbox_irq_ctrl;
  logic clk = 1'b0, rst_ni = 1'b0, en = 1'b1;
  logic cs_l = 0, we_l = 0, oe_l = 0, bz_l = 0, cs_r = 0, we_r = 0, oe_r = 0, bz_r = 0;
  logic [9:0] a_l = 10'h0, a_r = 10'h0;
  logic irq_l_n, irq_r_n;
  logic exp_l = 1'b0, exp_r = 1'b0;   // asserted state
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mbox_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .irq_en_i(en),
    .cs_left_i(cs_l), .we_left_i(we_l), .oe_left_i(oe_l), .busy_left_i(bz_l), .addr_left_i(a_l),
    .cs_right_i(cs_r), .we_right_i(we_r), .oe_right_i(oe_r), .busy_right_i(bz_r), .addr_right_i(a_r),
    .irq_left_no(irq_l_n), .irq_right_no(irq_r_n)
  );

  function automatic logic nxt(logic cur, logic e, logic s, logic c);
    if (!e) return 1'b0;
    if (s) return 1'b1;
    if (c) return 1'b0;
    return cur;
  endfunction

  task automatic chk(string tag, logic got, logic expv);
    checks++;
    if (got !== expv) begin
      errors++;
      $display("FAIL %s got=%b exp=%b t=%0t", tag, got, expv, $time);
    end
  endtask

  task automatic idle();
    cs_l = 0; we_l = 0; oe_l = 0; bz_l = 0; a_l = 10'h0;
    cs_r = 0; we_r = 0; oe_r = 0; bz_r = 0; a_r = 10'h0;
  endtask

  task automatic step(string tag);
    logic sl, cl, sr, cr;
    @(posedge clk);
    sl = cs_r && we_r && !bz_r && a_r == 10'h3FE;
    cl = cs_l && oe_l && a_l == 10'h3FE;
    sr = cs_l && we_l && !bz_l && a_l == 10'h3FF;
    cr = cs_r && oe_r && a_r == 10'h3FF;
    exp_l = nxt(exp_l, en, sl, cl);
    exp_r = nxt(exp_r, en, sr, cr);
    @(negedge clk);
    chk({tag, " left"}, irq_l_n, ~exp_l);
    chk({tag, " right"}, irq_r_n, ~exp_r);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #15;
    chk("R1 in reset left", irq_l_n, 1'b1);
    chk("R1 in reset right", irq_r_n, 1'b1);
    rst_ni = 1'b1;
    @(negedge clk);
    step("R1 after reset");
    // R2 set left
    cs_r = 1; we_r = 1; a_r = 10'h3FE; step("R2 set"); idle();
    step("R10 hold");
    // R4 clear with write level low
    cs_l = 1; oe_l = 1; a_l = 10'h3FE; step("R4 clear we0"); idle();
    cs_r = 1; we_r = 1; a_r = 10'h3FE; step("R2 set again"); idle();
    // R4 clear with write level high
    cs_l = 1; oe_l = 1; we_l = 1; a_l = 10'h3FE; step("R4 clear we1"); idle();
    // R3 / R5
    cs_l = 1; we_l = 1; a_l = 10'h3FF; step("R3 set"); idle();
    cs_r = 1; oe_r = 1; a_r = 10'h3FF; step("R5 clear"); idle();
    // R6 busy-blocked writes
    cs_r = 1; we_r = 1; bz_r = 1; a_r = 10'h3FE;
    cs_l = 1; we_l = 1; bz_l = 1; a_l = 10'h3FF; step("R6 busy"); idle();
    // R9 non-events
    cs_l = 1; we_l = 1; a_l = 10'h3FE; cs_r = 1; we_r = 1; a_r = 10'h3FF; step("R9 own mbox write"); idle();
    we_r = 1; a_r = 10'h3FE; step("R9 no cs"); idle();
    cs_r = 1; we_r = 1; a_r = 10'h1FE; step("R9 other addr"); idle();
    cs_l = 1; we_l = 1; a_l = 10'h3FF; step("R3 set"); idle();
    cs_l = 1; oe_l = 1; a_l = 10'h3FF; step("R9 read peer mbox"); idle();
    // R7 simultaneous set and clear
    cs_r = 1; we_r = 1; oe_r = 1; a_r = 10'h3FE; cs_l = 1; oe_l = 1; a_l = 10'h3FE; step("R7 left"); idle();
    cs_r = 1; oe_r = 1; a_r = 10'h3FF; cs_l = 1; we_l = 1; a_l = 10'h3FF; step("R7 right"); idle();
    // R8 enable off
    en = 0; step("R8 off");
    cs_r = 1; we_r = 1; a_r = 10'h3FE; cs_l = 1; we_l = 1; a_l = 10'h3FF; step("R8 set ignored"); idle();
    en = 1; step("R8 re-enabled");
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      cs_l = $urandom_range(0, 3) != 0; we_l = $urandom_range(0, 1) == 1;
      oe_l = $urandom_range(0, 2) == 0; bz_l = $urandom_range(0, 4) == 0;
      cs_r = $urandom_range(0, 3) != 0; we_r = $urandom_range(0, 1) == 1;
      oe_r = $urandom_range(0, 2) == 0; bz_r = $urandom_range(0, 4) == 0;
      a_l = ($urandom_range(0, 3) != 0) ? 10'h3FE + 10'($urandom_range(0, 1)) : 10'($urandom);
      a_r = ($urandom_range(0, 3) != 0) ? 10'h3FE + 10'($urandom_range(0, 1)) : 10'($urandom);
      en = $urandom_range(0, 19) != 0;
      step("R10 random");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule